// File: doc/BRIEF.md
# Binary-Decimal Column Compressor

This block handles one column of a decimal multiplier's partial-product array. A column holds a set of products of single decimal digits. Every product is a 7-bit binary value between 0 and 81, and all of them share one two-digit decimal position. The block reduces the set to one binary total. It does this with a chain of 3:2 carry-save compressors followed by a single binary adder.

The total is then turned into BCD by a shift-and-add-3 converter. The converter is sized for the largest total the column can reach, `81 * NUM_OPS`. The two least significant BCD digits are the column sum. The digits above them are the column carry. The neighbouring logic aligns these carries with other columns, which is why the carry is a separate output.

The block is purely combinational. Operand slots that are not used are tied to zero. With twelve operands or fewer, the carry is one digit wide. From thirteen operands upward, the carry grows to two digits.

Top module: `bdc_column`

## Requirements
- R1: `col_sum` holds the total of all operands modulo 100 as two BCD digits: bits [3:0] are the units digit and bits [7:4] are the tens digit.
- R2: `col_carry` holds the total divided by 100 (integer part) in BCD, with the least significant digit in bits [3:0].
- R3: With NUM_OPS = 12, `col_carry` is 4 bits wide. Twelve operands of 81 give `col_sum` = 8'h72 and `col_carry` = 4'h9.
- R4: With NUM_OPS = 13, `col_carry` is 8 bits wide. Thirteen operands of 81 give `col_sum` = 8'h53 and `col_carry` = 8'h10.
- R5: When every operand is zero, both outputs are zero.
- R6: The outputs do not depend on which slot an operand occupies. Reordering the operands leaves both outputs unchanged.
- R7: Every 4-bit digit of `col_sum` and `col_carry` lies in the range 0 to 9.
- R8: The outputs follow the operands within the same clock cycle, with no register on the path. This includes totals that roll over a hundreds boundary (99 to 100, and 999 to 1000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_vec | input | NUM_OPS*OP_W | Packed operands; operand i occupies bits [i*OP_W +: OP_W], each from 0 to OP_MAX |
| col_sum | output | 8 | Low two BCD digits of the column total |
| col_carry | output | 4*CARRY_DIG | Remaining BCD digits of the column total |

## Verification
A single change of operands can carry out of the units digit, the tens digit and the first carry digit together. This happens when the total crosses 99 to 100, or 999 to 1000. The sum and carry outputs must then both move in the same cycle, and they must stay valid BCD.

The bench builds operand sets that land exactly on each side of these boundaries, for twelve and for thirteen operands. It places them next to the all-maximum sets and random sets. Each result is judged against totals that the bench computes from plain integer arithmetic, and is sampled half a clock after the operands change.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

    // Number of bits needed to hold the value v (at least one).
    function automatic int bits_for(input int v);
        int n;
        n = 1;
        for (int k = 0; k < 31; k++) begin
            if ((v >> n) != 0) n++;
        end
        return n;
    endfunction

    // Number of decimal digits of v (at least one).
    function automatic int dec_digits(input int v);
        int n;
        int t;
        n = 1;
        t = v;
        for (int k = 0; k < 10; k++) begin
            if (t >= 10) begin
                t = t / 10;
                n++;
            end
        end
        return n;
    endfunction

    // Converter width in digits: two sum digits plus at least one carry digit.
    function automatic int conv_digits(input int v);
        return (dec_digits(v) < 3) ? 3 : dec_digits(v);
    endfunction

endpackage

// File: rtl/bdc_csa3.sv
// 3:2 carry-save compressor over a W-bit word.
module bdc_csa3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    logic [W-1:0] maj_d;

    always_comb begin
        sum_o = in_a ^ in_b ^ in_c;
        maj_d = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
        cry_o = maj_d << 1;
    end
endmodule

// File: rtl/bdc_compress.sv
// Reduces NUM_OPS binary operands to a redundant sum/carry pair with a CSA chain.
module bdc_compress #(
    parameter int NUM_OPS = 12,
    parameter int OP_W    = 7,
    parameter int W       = 10
) (
    input  logic [NUM_OPS*OP_W-1:0] ops_i,
    output logic [W-1:0]            sum_o,
    output logic [W-1:0]            cry_o
);
    localparam int STG = (NUM_OPS > 1) ? NUM_OPS - 1 : 1;

    logic [W-1:0] opx   [NUM_OPS];
    logic [W-1:0] s_stg [STG];
    logic [W-1:0] c_stg [STG];

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_ext
        assign opx[i] = W'(ops_i[i*OP_W +: OP_W]);
    end

    if (NUM_OPS == 1) begin : g_single
        assign s_stg[0] = opx[0];
        assign c_stg[0] = '0;
    end else begin : g_chain
        for (genvar k = 0; k < STG; k++) begin : g_stage
            if (k == 0) begin : g_head
                assign s_stg[0] = opx[0];
                assign c_stg[0] = opx[1];
            end else begin : g_csa
                bdc_csa3 #(.W(W)) u_csa (
                    .in_a  (s_stg[k-1]),
                    .in_b  (c_stg[k-1]),
                    .in_c  (opx[k+1]),
                    .sum_o (s_stg[k]),
                    .cry_o (c_stg[k])
                );
            end
        end
    end

    assign sum_o = s_stg[STG-1];
    assign cry_o = c_stg[STG-1];
endmodule

// File: rtl/bdc_bin2bcd.sv
// Shift-and-add-3 binary to BCD converter, fully unrolled.
module bdc_bin2bcd #(
    parameter int BIN_W = 10,
    parameter int DIG   = 3
) (
    input  logic [BIN_W-1:0] bin_i,
    output logic [4*DIG-1:0] bcd_o
);
    localparam int BCD_W = 4 * DIG;

    logic [BCD_W-1:0] acc_d;

    always_comb begin
        acc_d = '0;
        for (int i = BIN_W - 1; i >= 0; i--) begin
            for (int d = 0; d < DIG; d++) begin
                if (acc_d[4*d +: 4] >= 4'd5) acc_d[4*d +: 4] = acc_d[4*d +: 4] + 4'd3;
            end
            acc_d = {acc_d[BCD_W-2:0], bin_i[i]};
        end
        bcd_o = acc_d;
    end
endmodule

// File: rtl/bdc_column.sv
// One two-digit column: binary reduction, then decimal sum/carry split.
module bdc_column #(
    parameter int  NUM_OPS   = 12,
    parameter int  OP_W      = 7,
    parameter int  OP_MAX    = 81,
    localparam int CARRY_DIG = bdc_pkg::conv_digits(NUM_OPS * OP_MAX) - 2
) (
    input  logic [NUM_OPS*OP_W-1:0] op_vec,
    output logic [7:0]              col_sum,
    output logic [4*CARRY_DIG-1:0]  col_carry
);
    localparam int TOT_MAX  = NUM_OPS * OP_MAX;
    localparam int BIN_W    = bdc_pkg::bits_for(TOT_MAX);
    localparam int CONV_DIG = bdc_pkg::conv_digits(TOT_MAX);

    logic [BIN_W-1:0]      red_s;
    logic [BIN_W-1:0]      red_c;
    logic [BIN_W-1:0]      total_d;
    logic [4*CONV_DIG-1:0] bcd_d;

    bdc_compress #(
        .NUM_OPS (NUM_OPS),
        .OP_W    (OP_W),
        .W       (BIN_W)
    ) u_cmp (
        .ops_i (op_vec),
        .sum_o (red_s),
        .cry_o (red_c)
    );

    always_comb begin
        total_d = red_s + red_c;
    end

    bdc_bin2bcd #(
        .BIN_W (BIN_W),
        .DIG   (CONV_DIG)
    ) u_conv (
        .bin_i (total_d),
        .bcd_o (bcd_d)
    );

    always_comb begin
        col_sum   = bcd_d[7:0];
        col_carry = bcd_d[4*CONV_DIG-1:8];
    end
endmodule

// File: rtl/bdc_column_chk.sv
module bdc_column_chk #(
    parameter int  NUM_OPS   = 12,
    parameter int  OP_W      = 7,
    parameter int  OP_MAX    = 81,
    localparam int CARRY_DIG = bdc_pkg::conv_digits(NUM_OPS * OP_MAX) - 2
) (
    input logic [NUM_OPS*OP_W-1:0] op_vec,
    input logic [7:0]              col_sum,
    input logic [4*CARRY_DIG-1:0]  col_carry
);
    int tot;
    int cval;
    int wgt;
    bit in_rng;

    always_comb begin
        tot    = 0;
        in_rng = 1'b1;
        for (int i = 0; i < NUM_OPS; i++) begin
            tot = tot + int'(op_vec[i*OP_W +: OP_W]);
            if (int'(op_vec[i*OP_W +: OP_W]) > OP_MAX) in_rng = 1'b0;
        end
        cval = 0;
        wgt  = 1;
        for (int d = 0; d < CARRY_DIG; d++) begin
            cval = cval + wgt * int'(col_carry[4*d +: 4]);
            wgt  = wgt * 10;
        end

        AST_SUM_DIGITS_BCD: assert (col_sum[3:0] <= 4'd9 && col_sum[7:4] <= 4'd9); // R7
        for (int d = 0; d < CARRY_DIG; d++) begin
            AST_CARRY_DIGITS_BCD: assert (col_carry[4*d +: 4] <= 4'd9); // R7
        end
        if (in_rng) begin
            AST_COLUMN_VALUE: assert (cval * 100 + 10 * int'(col_sum[7:4]) + int'(col_sum[3:0]) == tot); // R1
            AST_CARRY_WITHIN_RANGE: assert (cval * 100 <= NUM_OPS * OP_MAX); // R3
        end
        if (tot == 0) begin
            AST_ZERO_COLUMN: assert (col_sum == 8'h00 && cval == 0); // R5
        end
    end
endmodule

bind bdc_column bdc_column_chk #(
    .NUM_OPS (NUM_OPS),
    .OP_W    (OP_W),
    .OP_MAX  (OP_MAX)
) u_chk (
    .op_vec    (op_vec),
    .col_sum   (col_sum),
    .col_carry (col_carry)
);

// File: tb/bdc_column_test.sv
module bdc_column_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    typedef struct {
        bit         wide;
        logic [7:0] s;
        logic [7:0] c;
        string      req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [90:0] op13 = '0;
    logic [83:0] op12 = '0;
    logic [7:0]  sum13;
    logic [7:0]  cry13;
    logic [7:0]  sum12;
    logic [3:0]  cry12;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    item_t sb[$];
    int    a13[13];
    int    a12[12];

    always #(CLK_PERIOD/2) clk = ~clk;

    bdc_column #(.NUM_OPS(13)) uut (
        .op_vec    (op13),
        .col_sum   (sum13),
        .col_carry (cry13)
    );

    bdc_column #(.NUM_OPS(12)) uut_m12 (
        .op_vec    (op12),
        .col_sum   (sum12),
        .col_carry (cry12)
    );

    function automatic logic [7:0] to_bcd2(input int v);
        return {4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go13(input string req);
        int t;
        @(posedge clk);
        #1;
        t = 0;
        for (int i = 0; i < 13; i++) begin
            op13[i*7 +: 7] = 7'(a13[i]);
            t += a13[i];
        end
        sb.push_back('{1'b1, to_bcd2(t % 100), to_bcd2(t / 100), req});
    endtask

    task automatic go12(input string req);
        int t;
        @(posedge clk);
        #1;
        t = 0;
        for (int i = 0; i < 12; i++) begin
            op12[i*7 +: 7] = 7'(a12[i]);
            t += a12[i];
        end
        sb.push_back('{1'b0, to_bcd2(t % 100), to_bcd2(t / 100), req});
    endtask

    // Monitor: compare outputs at the falling edge, in the cycle the operands were applied (R8)
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (it.wide) begin
                check(sum13 == it.s, {it.req, " sum m13"}, int'(sum13), int'(it.s));
                check(cry13 == it.c, {it.req, " carry m13"}, int'(cry13), int'(it.c));
                check(sum13[3:0] <= 9 && sum13[7:4] <= 9 && cry13[3:0] <= 9 && cry13[7:4] <= 9,
                      "R7 digits m13", int'({cry13, sum13}), 0);
            end else begin
                check(sum12 == it.s, {it.req, " sum m12"}, int'(sum12), int'(it.s));
                check(cry12 == it.c[3:0] && it.c[7:4] == 4'h0, {it.req, " carry m12"},
                      int'(cry12), int'(it.c));
                check(sum12[3:0] <= 9 && sum12[7:4] <= 9 && cry12 <= 9,
                      "R7 digits m12", int'({cry12, sum12}), 0);
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        // Reset state: zero operands give zero outputs (R5)
        repeat (3) @(posedge clk);
        #2;
        check(sum13 == 8'h00 && cry13 == 8'h00, "R5 zero m13", int'({cry13, sum13}), 0);
        check(sum12 == 8'h00 && cry12 == 4'h0, "R5 zero m12", int'({cry12, sum12}), 0);
        rst = 1'b0;

        // All operands at maximum (R3, R4)
        for (int i = 0; i < 13; i++) a13[i] = 81;
        for (int i = 0; i < 12; i++) a12[i] = 81;
        go13("R4 all-81");
        go12("R3 all-81");
        @(negedge clk);
        #1;
        check(sum13 == 8'h53 && cry13 == 8'h10, "R4 literal 1053", int'({cry13, sum13}), 'h1053);
        check(sum12 == 8'h72 && cry12 == 4'h9, "R3 literal 972", int'({cry12, sum12}), 'h972);

        // Boundary crossings 99/100 and 999/1000 (R8, R1, R2)
        for (int i = 0; i < 13; i++) a13[i] = 0;
        a13[0] = 81; a13[7] = 18;
        go13("R8 total 99");
        a13[7] = 19;
        go13("R8 total 100");
        for (int i = 0; i < 12; i++) a13[i] = 81;
        a13[12] = 27;
        go13("R8 total 999");
        a13[12] = 28;
        go13("R8 total 1000");
        for (int i = 0; i < 12; i++) a12[i] = 81;
        a12[11] = 9;
        go12("R2 total 900");
        a12[11] = 8;
        go12("R2 total 899");

        // Single operand in the last slot (R1)
        for (int i = 0; i < 12; i++) a12[i] = 0;
        a12[11] = 57;
        go12("R1 last slot");

        // Back to zero after activity (R5)
        for (int i = 0; i < 13; i++) a13[i] = 0;
        go13("R5 zero again");

        // Random sets (R1, R2)
        for (int n = 0; n < 30; n++) begin
            for (int i = 0; i < 13; i++) a13[i] = int'($urandom_range(0, 81));
            for (int i = 0; i < 12; i++) a12[i] = int'($urandom_range(0, 81));
            go13("R1 R2 random");
            go12("R1 R2 random");
        end

        // Reordered operands give the same result (R6)
        for (int n = 0; n < 5; n++) begin
            for (int i = 0; i < 13; i++) a13[i] = int'($urandom_range(0, 81));
            go13("R6 forward");
            for (int i = 0; i < 6; i++) begin
                int tmp;
                tmp = a13[i];
                a13[i] = a13[12 - i];
                a13[12 - i] = tmp;
            end
            go13("R6 reversed");
        end

        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule